// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block sits between two active-low external request pins and an interrupt controller. It turns raw pin activity into clean per-channel pending flags in the core clock domain. Each channel is configured on its own to be either level-sensitive or triggered by a falling edge. Each channel also has an enable bit. Edge-triggered flags are held until software clears them by writing a one to a clear mask. Level flags follow the synchronized pin.

While the core runs, every pin passes through a multi-stage synchronizer. Edges are found by comparing the synchronized value with its value one cycle earlier. While the chip is in a stop or wait state, the core clock may be gated. In that state each enabled channel arms a capture flop that is clocked by the pin itself. A falling edge on the pin then raises the wake-up output at once, with no clock needed. When the clock runs again, the capture is carried into the clock domain. It sets the edge-mode pending flag, so a pulse shorter than a clock period is not lost. The capture flop is then cleared by a synchronized acknowledge once the low-power state has been left.

Top module: `irq_conditioner`

## Requirements
- R1: After reset every pending flag, `irq_any` and `wake` are 0. Every channel comes out of reset disabled and in level mode, so a low pin raises no pending flag.
- R2: With a channel enabled and its `cfg_edge` bit at 0 (level mode), `pending[i]` equals the inverted pin. A change on the pin shows on `pending[i]` after exactly two rising clock edges.
- R3: With a channel enabled and its `cfg_edge` bit at 1 (falling-edge mode), a high-to-low pin transition sets `pending[i]` after exactly three rising clock edges. The flag then stays set after the pin returns high.
- R4: A cycle with `clr_we`=1 clears the edge-mode pending flag of each channel whose `clr_mask` bit is 1, and leaves channels whose bit is 0 untouched. If a new edge and a clear reach a channel on the same clock edge, the flag stays set.
- R5: The channels are independent: activity on one pin never changes the pending flag of the other channel.
- R6: A disabled channel never shows pending. Disabling an edge-mode channel discards its held flag, so it is still 0 after the channel is enabled again.
- R7: With `low_power`=1, a falling edge on the pin of an enabled channel raises `wake` with no clock edge needed. This also holds for a low pulse shorter than a clock period. A disabled channel never raises `wake`.
- R8: `wake` stays high for as long as `low_power` stays 1. Once `low_power` returns to 0, `wake` drops within two rising clock edges. A short pulse captured this way sets the edge-mode pending flag of its channel.
- R9: With `low_power`=0, pin edges never raise `wake`.
- R10: `irq_any` is 1 exactly when at least one `pending` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | NUM_CH | Active-low external request pins, asynchronous |
| low_power | input | 1 | 1 while the chip is in a stop or wait state |
| cfg_we | input | 1 | Loads `cfg_en` and `cfg_edge` on the next clock edge |
| cfg_en | input | NUM_CH | Per-channel enable |
| cfg_edge | input | NUM_CH | Per-channel trigger: 0 level, 1 falling edge |
| clr_we | input | 1 | Clear strobe for edge-mode flags |
| clr_mask | input | NUM_CH | Write-one-to-clear mask |
| pending | output | NUM_CH | Per-channel pending flags |
| irq_any | output | 1 | OR of all pending flags |
| wake | output | 1 | Asynchronous wake-up request |

## Verification
The bench builds the block with its defaults, NUM_CH=2 and SYNC_STAGES=2. Two channels are enough to set one channel in level mode and the other in edge mode at the same time, which exercises independence. A two-stage synchronizer fixes the latencies at two and three clock edges. The bench samples one edge early and then on the exact edge, so a wrong pipeline depth is caught. Low-power pulses are driven entirely between clock edges, so only the pin-clocked capture path can report them.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_FALL  = 1'b1
    } trig_e;

    typedef struct packed {
        logic  en;
        trig_e trig;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{en: 1'b0, trig: TRIG_LEVEL};

    function automatic logic fall_seen(input logic prev_lvl, input logic cur_lvl);
        return prev_lvl & ~cur_lvl;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irqc_wake_cap.sv
module irqc_wake_cap #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n,
    input  logic arm,
    input  logic low_power,
    output logic cap,
    output logic cap_evt
);
    logic ack_q;
    logic cap_s;
    logic cap_prev;

    // Capture flop clocked by the pin; cleared by the acknowledge from the clock domain
    always_ff @(negedge req_n or posedge ack_q) begin
        if (ack_q)    cap <= 1'b0;
        else if (arm) cap <= 1'b1;
    end

    irqc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cap_sync (
        .clk (clk),
        .rst (rst),
        .d   (cap),
        .q   (cap_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q    <= 1'b1;
            cap_prev <= 1'b0;
        end else begin
            ack_q    <= cap_s & ~low_power;
            cap_prev <= cap_s;
        end
    end

    assign cap_evt = cap_s & ~cap_prev;

    // R8
    ack_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_q && !$past(rst)) |-> $past(!low_power));
endmodule

// File: rtl/irqc_chan.sv
module irqc_chan
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg,
    input  logic      req_n,
    input  logic      cap_evt,
    input  logic      clr,
    output logic      pend
);
    logic lvl_s;
    logic lvl_prev;
    logic edge_mode;
    logic set_evt;
    logic pend_ff;

    irqc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_n),
        .q   (lvl_s)
    );

    always_ff @(posedge clk) begin
        if (rst) lvl_prev <= 1'b1;
        else     lvl_prev <= lvl_s;
    end

    assign edge_mode = cfg.en && (cfg.trig == TRIG_FALL);
    assign set_evt   = edge_mode && (fall_seen(lvl_prev, lvl_s) || cap_evt);

    always_ff @(posedge clk) begin
        if (rst || !edge_mode) pend_ff <= 1'b0;
        else if (set_evt)      pend_ff <= 1'b1;
        else if (clr)          pend_ff <= 1'b0;
    end

    always_comb begin
        if (!cfg.en)         pend = 1'b0;
        else if (edge_mode)  pend = pend_ff;
        else                 pend = ~lvl_s;
    end

    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && pend_ff && !clr) |=> pend_ff);

    // R4
    edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && clr && !set_evt) |=> !pend_ff);

    // R6
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg.en && $past(!cfg.en)) |-> !pend_ff);
endmodule

// File: rtl/irq_conditioner.sv
module irq_conditioner
    import irqc_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req_n,
    input  logic              low_power,
    input  logic              cfg_we,
    input  logic [NUM_CH-1:0] cfg_en,
    input  logic [NUM_CH-1:0] cfg_edge,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] clr_mask,
    output logic [NUM_CH-1:0] pending,
    output logic              irq_any,
    output logic              wake
);
    chan_cfg_t         cfg_q [NUM_CH];
    logic [NUM_CH-1:0] cap;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CH; i++) begin
            if (rst)         cfg_q[i] <= CFG_RESET;
            else if (cfg_we) cfg_q[i] <= '{en: cfg_en[i], trig: trig_e'(cfg_edge[i])};
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic cap_evt;

        irqc_wake_cap #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
            .clk       (clk),
            .rst       (rst),
            .req_n     (req_n[g]),
            .arm       (low_power & cfg_q[g].en),
            .low_power (low_power),
            .cap       (cap[g]),
            .cap_evt   (cap_evt)
        );

        irqc_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .cfg     (cfg_q[g]),
            .req_n   (req_n[g]),
            .cap_evt (cap_evt),
            .clr     (clr_we & clr_mask[g]),
            .pend    (pending[g])
        );
    end

    assign wake    = |cap;
    assign irq_any = |pending;

    // R9
    run_no_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (!low_power && $past(!low_power) && !$past(wake)) |-> !wake);

    // R8
    wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (low_power && $past(low_power) && $past(wake)) |-> wake);
endmodule

// File: tb/irq_conditioner_tb.sv
module irq_conditioner_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req_n = '1;
    logic         low_power = 1'b0;
    logic         cfg_we = 1'b0;
    logic [N-1:0] cfg_en = '0;
    logic [N-1:0] cfg_edge = '0;
    logic         clr_we = 1'b0;
    logic [N-1:0] clr_mask = '0;
    logic [N-1:0] pending;
    logic         irq_any;
    logic         wake;

    int vectors = 0;
    int errors  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_conditioner #(.NUM_CH(N), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .req_n(req_n), .low_power(low_power),
        .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_edge(cfg_edge),
        .clr_we(clr_we), .clr_mask(clr_mask),
        .pending(pending), .irq_any(irq_any), .wake(wake)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic configure(input logic [N-1:0] en, input logic [N-1:0] edg);
        cfg_en = en; cfg_edge = edg; cfg_we = 1'b1;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic clear(input logic [N-1:0] m);
        clr_mask = m; clr_we = 1'b1;
        tick(1);
        clr_we = 1'b0; clr_mask = '0;
    endtask

    task automatic t_reset;
        check("R1 pending", |pending, 1'b0);
        check("R1 irq_any", irq_any, 1'b0);
        check("R1 wake", wake, 1'b0);
        req_n = '0;
        tick(4);
        check("R1 disabled low pin", |pending, 1'b0);
        req_n = '1;
        tick(3);
    endtask

    task automatic t_level;
        configure(2'b11, 2'b00);
        req_n[0] = 1'b0;
        tick(1);
        check("R2 one edge early", pending[0], 1'b0);
        tick(1);
        check("R2 level set", pending[0], 1'b1);
        check("R5 other channel", pending[1], 1'b0);
        check("R10 irq_any set", irq_any, 1'b1);
        req_n[0] = 1'b1;
        tick(2);
        check("R2 level follows", pending[0], 1'b0);
        check("R10 irq_any clear", irq_any, 1'b0);
    endtask

    task automatic t_edge;
        configure(2'b11, 2'b10);
        req_n[1] = 1'b0;
        tick(2);
        check("R3 two edges early", pending[1], 1'b0);
        tick(1);
        check("R3 edge set", pending[1], 1'b1);
        check("R9 no wake in run", wake, 1'b0);
        check("R5 level channel idle", pending[0], 1'b0);
        req_n[1] = 1'b1;
        tick(4);
        check("R3 held after release", pending[1], 1'b1);
        clear(2'b01);
        check("R4 other mask bit", pending[1], 1'b1);
        clear(2'b10);
        check("R4 cleared", pending[1], 1'b0);
        req_n[1] = 1'b0;
        tick(2);
        clear(2'b10);
        check("R4 set wins over clear", pending[1], 1'b1);
        req_n[1] = 1'b1;
        tick(3);
        configure(2'b01, 2'b10);
        check("R6 disabled hides flag", pending[1], 1'b0);
        configure(2'b11, 2'b10);
        tick(2);
        check("R6 flag discarded", pending[1], 1'b0);
    endtask

    task automatic t_low_power;
        configure(2'b01, 2'b11);
        tick(3);
        low_power = 1'b1;
        tick(1);
        req_n[1] = 1'b0; #2; req_n[1] = 1'b1; #1;
        check("R7 disabled no wake", wake, 1'b0);
        tick(1);
        req_n[0] = 1'b0; #2; req_n[0] = 1'b1; #1;
        check("R7 short pulse wakes", wake, 1'b1);
        tick(5);
        check("R8 wake held", wake, 1'b1);
        check("R8 capture sets flag", pending[0], 1'b1);
        low_power = 1'b0;
        tick(2);
        check("R8 wake released", wake, 1'b0);
        check("R8 flag kept", pending[0], 1'b1);
        check("R5 disabled channel", pending[1], 1'b0);
        clear(2'b01);
        check("R4 clear after wake", pending[0], 1'b0);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_level();
        t_edge();
        t_low_power();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule